// File: doc/BRIEF.md
# Segmented Linear Address Generator

This unit turns the addressing fields of one memory operand into the addresses a memory access needs. It adds an optional base register value, an optional index value scaled by 1, 2, 4 or 8, and a sign-extended displacement to form the effective address. It then picks a segment, either by the kind of reference or through an override, and adds that segment's starting point to reach a linear address. The low bits of the linear address form the physical address when paging is off.

Two address widths are supported: 32-bit addressing and a 16-bit addressing mode whose offsets must stay inside 64 KB. Two segmentation modes are supported. In real mode the segment start is the 16-bit selector times 16, and the result wraps inside 1 MB. In protected mode the segment start is a 32-bit base taken from a per-segment input, and the result is cut to 24 physical bits. Operands that use no address term or one address term leave the unit one cycle after they are accepted. An operand with both a base and an index takes one more cycle, and the unit refuses new input during that cycle.

Top module: `addr_gen`

## Requirements
- R1: With `addr32`=1 the effective address is (base + (index << scale) + displacement) mod 2^32. An absent term (its enable low) counts as zero. `disp_size` codes: 0 = no displacement, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit, each sign-extended.
- R2: With `addr32`=0 only the low 16 bits of base and index are used, `disp_size`=3 is treated as a 16-bit displacement, and the effective address is the sum mod 2^16 (bits 31:16 of `out_ea` are zero).
- R3: With `addr32`=0, `out_fault` is set when the unwrapped sum is above 0xFFFF or below zero; a sum of exactly 0xFFFF does not fault.
- R4: With `addr32`=1, an enabled index with `idx_reg`=4 (the stack pointer) sets `out_fault`; with `addr32`=0 that register number causes no fault.
- R5: Segment codes are 0 extra, 1 code, 2 stack, 3 data, 4 aux-one, 5 aux-two. The default segment by `ref_kind` is: 0 instruction fetch → 1, 1 stack push/pop → 2, 2 string destination → 0, 3 other data → 3.
- R6: When `ovr_en`=1, `ovr_seg` replaces the default only for `ref_kind` 1 and 3, and only when `ovr_seg` ≤ 5. For kinds 0 and 2, or for codes 6 and 7, the override has no effect.
- R7: With `prot_mode`=0 the physical address is ((selector << 4) + effective address) mod 2^20, zero-extended to 24 bits. An effective address above 0xFFFF sets `out_fault`.
- R8: With `prot_mode`=1 the physical address is the low 24 bits of (segment base + effective address).
- R9: An operand without both base and index gives `out_valid` one cycle after acceptance. An operand with both gives it two cycles after acceptance. In the cycle between, `in_ready` is low and any `in_valid` is ignored.
- R10: During and right after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_ready | output | 1 | Unit accepts an operand this cycle |
| base_en | input | 1 | Base term used |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index term used |
| idx_reg | input | 3 | Register number of the index |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp | input | 32 | Displacement bits |
| disp_size | input | 2 | Displacement size code |
| ref_kind | input | 2 | Reference kind |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment code |
| prot_mode | input | 1 | 1 protected, 0 real mode |
| addr32 | input | 1 | 1 for 32-bit addressing, 0 for 16-bit |
| seg_bases | input | 192 | Six 32-bit protected-mode bases, segment code n at bits 32n+31:32n |
| seg_sels | input | 96 | Six 16-bit selectors, segment code n at bits 16n+15:16n |
| out_valid | output | 1 | Result present |
| out_ea | output | 32 | Effective address |
| out_phys | output | 24 | Physical address |
| out_fault | output | 1 | Address fault |

## Verification
Results of operands with fewer than two address terms are due at the first falling edge after the accepting clock edge. Base-plus-index results are due one falling edge later. The driver stamps each expected item with that due cycle from a free-running cycle count. The monitor compares the stamp with the cycle in which `out_valid` is seen, so an early, late, missing or extra result is a failure just as a wrong address is. The stall cycle is probed by driving a stray operand while `in_ready` is low, with no expected item queued for it.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 16;
    localparam int NSEG    = 6;
    localparam int PHYS_W  = 24;
    localparam int SHORT_W = 16;
    localparam int SUM_W   = ADDR_W + 5;
    localparam int REAL_W  = SEL_W + 4;
    localparam int SEGC_W  = 3;

    typedef enum logic [1:0] {
        RK_FETCH  = 2'd0,
        RK_STACK  = 2'd1,
        RK_STRDST = 2'd2,
        RK_DATA   = 2'd3
    } ref_kind_e;

    typedef enum logic [SEGC_W-1:0] {
        SG_EXTRA = 3'd0,
        SG_CODE  = 3'd1,
        SG_STACK = 3'd2,
        SG_DATA  = 3'd3,
        SG_AUX1  = 3'd4,
        SG_AUX2  = 3'd5
    } seg_code_e;

    // operand state entering the final adder
    typedef struct packed {
        logic [SUM_W-1:0]  term;
        logic [SUM_W-1:0]  disp;
        logic              wide;
        logic              prot;
        logic [ADDR_W-1:0] segb;
        logic              sp_idx;
    } partial_t;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [PHYS_W-1:0] phys;
        logic              fault;
    } result_t;

    function automatic seg_code_e default_seg(input ref_kind_e k);
        case (k)
            RK_FETCH:  return SG_CODE;
            RK_STACK:  return SG_STACK;
            RK_STRDST: return SG_EXTRA;
            default:   return SG_DATA;
        endcase
    endfunction

    function automatic logic [SUM_W-1:0] sext_disp(
        input logic [ADDR_W-1:0] d,
        input logic [1:0]        sz,
        input logic              wide
    );
        case (sz)
            2'd0:    return '0;
            2'd1:    return {{(SUM_W-8){d[7]}}, d[7:0]};
            2'd2:    return {{(SUM_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
            default: return wide ? {{(SUM_W-ADDR_W){d[ADDR_W-1]}}, d}
                                 : {{(SUM_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
        endcase
    endfunction

endpackage

// File: rtl/seg_pick.sv
module seg_pick
    import addr_gen_pkg::*;
(
    input  ref_kind_e                   kind,
    input  logic                        ovr_en,
    input  logic [SEGC_W-1:0]           ovr_code,
    input  logic                        prot,
    input  logic [NSEG*ADDR_W-1:0]      bases,
    input  logic [NSEG*SEL_W-1:0]       sels,
    output logic [ADDR_W-1:0]           segb
);
    logic [ADDR_W-1:0] base_arr [NSEG];
    logic [SEL_W-1:0]  sel_arr  [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign base_arr[g] = bases[g*ADDR_W +: ADDR_W];
        assign sel_arr[g]  = sels[g*SEL_W +: SEL_W];
    end

    logic      ovr_ok;
    seg_code_e chosen;

    always_comb begin
        ovr_ok = ovr_en && (kind == RK_STACK || kind == RK_DATA)
                 && (int'(ovr_code) < NSEG);
        chosen = ovr_ok ? seg_code_e'(ovr_code) : default_seg(kind);
    end

    // real mode start is the selector times 16
    always_comb begin
        if (prot)
            segb = base_arr[chosen];
        else
            segb = {{(ADDR_W-REAL_W){1'b0}}, sel_arr[chosen], 4'b0000};
    end

endmodule

// File: rtl/ea_finish.sv
module ea_finish
    import addr_gen_pkg::*;
(
    input  partial_t p,
    output result_t  r
);
    logic [SUM_W-1:0]  total;
    logic              short_ovf;
    logic              real_ovf;
    logic [ADDR_W-1:0] lin;

    always_comb begin
        total     = p.term + p.disp;
        // negative sums show as the top bit set, large ones above bit 15
        short_ovf = !p.wide && (total[SUM_W-1] || (|total[SUM_W-2:SHORT_W]));
        r.ea      = p.wide ? total[ADDR_W-1:0]
                           : {{(ADDR_W-SHORT_W){1'b0}}, total[SHORT_W-1:0]};
        real_ovf  = !p.prot && (|r.ea[ADDR_W-1:SHORT_W]);
        lin       = p.segb + r.ea;
        r.phys    = p.prot ? lin[PHYS_W-1:0]
                           : {{(PHYS_W-REAL_W){1'b0}}, lin[REAL_W-1:0]};
        r.fault   = short_ovf || real_ovf || p.sp_idx;
    end

endmodule

// File: rtl/addr_gen.sv
module addr_gen
    import addr_gen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    base_en,
    input  logic [31:0]             base_val,
    input  logic                    idx_en,
    input  logic [2:0]              idx_reg,
    input  logic [31:0]             idx_val,
    input  logic [1:0]              scale,
    input  logic [31:0]             disp,
    input  logic [1:0]              disp_size,
    input  logic [1:0]              ref_kind,
    input  logic                    ovr_en,
    input  logic [2:0]              ovr_seg,
    input  logic                    prot_mode,
    input  logic                    addr32,
    input  logic [191:0]            seg_bases,
    input  logic [95:0]             seg_sels,
    output logic                    out_valid,
    output logic [31:0]             out_ea,
    output logic [23:0]             out_phys,
    output logic                    out_fault
);
    localparam logic [2:0] SP_REG = 3'd4;
    localparam int         PAD_W  = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] segb;
    logic [SUM_W-1:0]  b_ext, x_ext, d_ext;
    logic              slow, accept;
    partial_t          fresh, hold_q, fin_in;
    logic              hold_v;
    result_t           res;

    seg_pick u_seg (
        .kind     (ref_kind_e'(ref_kind)),
        .ovr_en   (ovr_en),
        .ovr_code (ovr_seg),
        .prot     (prot_mode),
        .bases    (seg_bases),
        .sels     (seg_sels),
        .segb     (segb)
    );

    always_comb begin
        b_ext = '0;
        x_ext = '0;
        if (base_en)
            b_ext = SUM_W'(addr32 ? base_val : {{PAD_W{1'b0}}, base_val[SHORT_W-1:0]});
        if (idx_en)
            x_ext = SUM_W'(addr32 ? idx_val : {{PAD_W{1'b0}}, idx_val[SHORT_W-1:0]}) << scale;
        d_ext = sext_disp(disp, disp_size, addr32);

        slow   = base_en && idx_en;
        accept = in_valid && !hold_v;

        fresh.term   = base_en ? b_ext : x_ext;
        fresh.disp   = d_ext;
        fresh.wide   = addr32;
        fresh.prot   = prot_mode;
        fresh.segb   = segb;
        fresh.sp_idx = addr32 && idx_en && (idx_reg == SP_REG);

        fin_in = hold_v ? hold_q : fresh;
    end

    ea_finish u_fin (
        .p (fin_in),
        .r (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            hold_q    <= '0;
            out_valid <= 1'b0;
            out_ea    <= '0;
            out_phys  <= '0;
            out_fault <= 1'b0;
        end else begin
            hold_v <= accept && slow;
            if (accept && slow) begin
                hold_q      <= fresh;
                hold_q.term <= b_ext + x_ext;
            end
            out_valid <= hold_v || (accept && !slow);
            if (hold_v || (accept && !slow)) begin
                out_ea    <= res.ea;
                out_phys  <= res.phys;
                out_fault <= res.fault;
            end
        end
    end

    assign in_ready = !hold_v;

    p_stall_one_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && base_en && idx_en) |=> !in_ready ##1 in_ready);

    p_slow_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && base_en && idx_en) |=> !out_valid ##1 out_valid);

    p_fast_lat_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !(base_en && idx_en)) |=> out_valid);

    p_sp_index_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !base_en && idx_en && addr32 && idx_reg == SP_REG)
        |=> out_fault);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

endmodule

// File: tb/test_addr_gen.sv
module test_addr_gen;

    typedef struct packed {
        logic        be;
        logic [31:0] bv;
        logic        ie;
        logic [2:0]  ir;
        logic [31:0] iv;
        logic [1:0]  sc;
        logic [31:0] d;
        logic [1:0]  ds;
        logic [1:0]  rk;
        logic        oe;
        logic [2:0]  os;
        logic        pm;
        logic        w;
    } stim_t;

    typedef struct {
        logic [31:0] ea;
        logic [23:0] phys;
        logic        fault;
        int          due;
        string       tag;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0, in_ready;
    logic base_en = 0, idx_en = 0, ovr_en = 0, prot_mode = 0, addr32 = 0;
    logic [31:0] base_val = 0, idx_val = 0, disp = 0;
    logic [2:0] idx_reg = 0, ovr_seg = 0;
    logic [1:0] scale = 0, disp_size = 0, ref_kind = 0;
    logic [191:0] seg_bases;
    logic [95:0] seg_sels;
    logic out_valid, out_fault;
    logic [31:0] out_ea;
    logic [23:0] out_phys;

    logic [31:0] bases [6];
    logic [15:0] sels [6];

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    exp_t q[$];
    stim_t st;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int i = 0; i < 6; i++) begin
            seg_bases[i*32 +: 32] = bases[i];
            seg_sels[i*16 +: 16]  = sels[i];
        end
    end

    addr_gen i_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .base_en(base_en), .base_val(base_val), .idx_en(idx_en), .idx_reg(idx_reg),
        .idx_val(idx_val), .scale(scale), .disp(disp), .disp_size(disp_size),
        .ref_kind(ref_kind), .ovr_en(ovr_en), .ovr_seg(ovr_seg), .prot_mode(prot_mode),
        .addr32(addr32), .seg_bases(seg_bases), .seg_sels(seg_sels),
        .out_valid(out_valid), .out_ea(out_ea), .out_phys(out_phys), .out_fault(out_fault)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // expected result computed from the requirements
    function automatic exp_t model(input stim_t s);
        exp_t e;
        longint b, x, d, sum, ea, segb, lin;
        int sg;
        b = !s.be ? 0 : (s.w ? longint'(s.bv) : longint'(s.bv[15:0]));
        x = !s.ie ? 0 : (s.w ? longint'(s.iv) : longint'(s.iv[15:0]));
        x = x * (64'd1 << s.sc);
        case (s.ds)
            2'd0: d = 0;
            2'd1: d = longint'($signed(s.d[7:0]));
            2'd2: d = longint'($signed(s.d[15:0]));
            default: d = s.w ? longint'($signed(s.d)) : longint'($signed(s.d[15:0]));
        endcase
        sum = b + x + d;
        ea = s.w ? (sum & 64'hFFFF_FFFF) : (sum & 64'hFFFF);
        case (s.rk)
            2'd0: sg = 1;
            2'd1: sg = 2;
            2'd2: sg = 0;
            default: sg = 3;
        endcase
        if (s.oe && (s.rk == 2'd1 || s.rk == 2'd3) && s.os <= 3'd5) sg = int'(s.os);
        segb = s.pm ? longint'(bases[sg]) : longint'(sels[sg]) * 16;
        lin = segb + ea;
        e.ea = ea[31:0];
        e.phys = s.pm ? lin[23:0] : {4'h0, lin[19:0]};
        e.fault = (!s.w && (sum < 0 || sum > 65535)) || (!s.pm && ea > 65535)
                  || (s.w && s.ie && s.ir == 3'd4);
        e.due = 0;
        e.tag = "";
        return e;
    endfunction

    task automatic apply(input stim_t s);
        base_en = s.be; base_val = s.bv; idx_en = s.ie; idx_reg = s.ir;
        idx_val = s.iv; scale = s.sc; disp = s.d; disp_size = s.ds;
        ref_kind = s.rk; ovr_en = s.oe; ovr_seg = s.os; prot_mode = s.pm; addr32 = s.w;
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic go(input string tag);
        exp_t e;
        while (!in_ready) @(negedge clk);
        apply(st);
        in_valid = 1;
        e = model(st);
        e.due = cyc + ((st.be && st.ie) ? 2 : 1);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        in_valid = 0;
    endtask

    // monitor: scoreboard pop and compare, including the due cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(0, "R9", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.due, e.tag, "cycle", cyc, e.due);
                    check(out_ea == e.ea, e.tag, "ea", out_ea, e.ea);
                    check(out_phys == e.phys, e.tag, "phys", out_phys, e.phys);
                    check(out_fault == e.fault, e.tag, "fault", out_fault, e.fault);
                end
            end else if (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                check(0, e.tag, "missing result at cycle", cyc, e.due);
            end
        end
    end

    initial begin
        #200000;
        check(0, "R9", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bases[0] = 32'h00A0_0000; bases[1] = 32'h00B1_0000; bases[2] = 32'h00C2_0000;
        bases[3] = 32'h00D3_0000; bases[4] = 32'h00E4_0000; bases[5] = 32'hFFF5_0000;
        sels[0] = 16'h1000; sels[1] = 16'h2000; sels[2] = 16'h3000;
        sels[3] = 16'h4000; sels[4] = 16'h5000; sels[5] = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R10", "out_valid in reset", out_valid, 0);
        check(in_ready == 1, "R10", "in_ready in reset", in_ready, 1);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);

        // R1: 32-bit forms, protected data segment
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3;
        st.be = 1; st.bv = 32'h0000_1000; st.d = 32'h0000_00F8; st.ds = 2'd1; go("R1");
        st.bv = 32'hFFFF_FFF0; st.d = 32'h0000_0020; st.ds = 2'd3; go("R1");
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3;
        st.ie = 1; st.ir = 3'd1; st.iv = 32'h0000_0100; st.sc = 2'd3;
        st.d = 32'h1234_0000; st.ds = 2'd3; go("R1");
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3; st.d = 32'h0000_8000; st.ds = 2'd2; go("R1");
        // R9: base plus index, two cycles
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3;
        st.be = 1; st.bv = 32'h0002_0000; st.ie = 1; st.ir = 3'd2; st.iv = 32'h10; st.sc = 2'd2;
        st.d = 32'h0000_0004; st.ds = 2'd1; go("R9");
        // stray operand in the stall cycle must be ignored
        check(in_ready == 0, "R9", "in_ready in stall", in_ready, 0);
        in_valid = 1; base_en = 0; idx_en = 0; disp = 32'hDEAD; disp_size = 2'd2;
        @(negedge clk);
        in_valid = 0;
        check(in_ready == 1, "R9", "in_ready after stall", in_ready, 1);
        // back-to-back single-term operands
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3; st.be = 1; st.bv = 32'h40; go("R9");
        st.bv = 32'h80; go("R9");

        // R2 and R3: 16-bit addressing
        st = '0; st.w = 0; st.pm = 1; st.rk = 2'd3;
        st.be = 1; st.bv = 32'h0001_2345; st.d = 32'hFFFF_0010; st.ds = 2'd3; go("R2");
        st.bv = 32'h0000_FFF0; st.d = 32'h20; st.ds = 2'd1; go("R3");
        st.bv = 32'h0000_0004; st.d = 32'hF8; st.ds = 2'd1; go("R3");
        st.bv = 32'h0000_FFF0; st.d = 32'h0F; st.ds = 2'd1; go("R3");
        st = '0; st.w = 0; st.pm = 1; st.rk = 2'd3;
        st.be = 1; st.bv = 32'hFF00; st.ie = 1; st.iv = 32'h0040; st.sc = 2'd2; go("R3");

        // R4: stack pointer as index
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3; st.ie = 1; st.ir = 3'd4; st.iv = 32'h10; go("R4");
        st.w = 0; go("R4");

        // R5: default segment per kind
        for (int k = 0; k < 4; k++) begin
            st = '0; st.w = 1; st.pm = 1; st.rk = 2'(k); st.d = 32'h0000_0123; st.ds = 2'd2;
            go("R5");
        end

        // R6: overrides
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3; st.oe = 1; st.os = 3'd4;
        st.d = 32'h55; st.ds = 2'd1; go("R6");
        st.rk = 2'd1; st.os = 3'd5; go("R6");
        st.rk = 2'd0; st.os = 3'd4; go("R6");
        st.rk = 2'd2; st.os = 3'd5; go("R6");
        st.rk = 2'd3; st.os = 3'd7; go("R6");

        // R7: real mode
        st = '0; st.w = 0; st.pm = 0; st.rk = 2'd3;
        st.be = 1; st.bv = 32'h1234; st.d = 32'h10; st.ds = 2'd1; go("R7");
        st.oe = 1; st.os = 3'd5; st.bv = 32'h0000_0020; st.ds = 2'd0; go("R7");
        st = '0; st.w = 1; st.pm = 0; st.rk = 2'd3;
        st.be = 1; st.bv = 32'h0001_0000; go("R7");

        // R8: protected 24-bit truncation
        st = '0; st.w = 1; st.pm = 1; st.rk = 2'd3; st.oe = 1; st.os = 3'd5;
        st.be = 1; st.bv = 32'h0123_4567; go("R8");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9", "results outstanding", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule